// File: doc/BRIEF.md
# Borrow-Chained Subtract Unit with Single Flag

This block is one execution slice of a 32-bit integer core. It handles the register-to-register instructions that subtract, negate, invert or byte-swap and that use a single status bit, called T here, as borrow input, borrow output or overflow output. Each cycle it may accept a 16-bit instruction word, the two source operands (the source register value and the destination register's current value) and the current T. One cycle later it presents the new destination value and the new T.

Only bits 15:12 (instruction class) and bits 3:0 (function) of the instruction word are decoded. Bits 11:4 carry the register numbers, which the surrounding core already used to fetch the operands, so the unit ignores them. Any class and function pair outside the supported set raises an illegal-instruction flag. In that case the destination value and T pass through unchanged.

All borrow-producing operations share a single 33-bit subtractor. The two chained forms feed T in as an extra borrow, so the borrow out of bit 32 equals the OR of the borrows from the two steps.

Top module: `tflag_alu`

## Requirements
- R1: While reset is held and after it is released, before any accepted instruction, outValid, illegal, rnOut and tOut are all 0.
- R2: outValid is 1 exactly in the cycle after a cycle with inValid at 1, and one result is produced for every accepted instruction.
- R3: Class 0x3 with function 0x8 (plain subtract) gives rnOut = rnIn − rmIn modulo 2^32, and tOut equals the incoming T.
- R4: Class 0x3 with function 0xA (subtract with borrow) gives rnOut = rnIn − T − rmIn modulo 2^32. tOut is 1 exactly when T + rmIn, taken as unsigned, exceeds rnIn.
- R5: Class 0x6 with function 0xA (negate with borrow) gives rnOut = 0 − T − rmIn modulo 2^32. tOut is 1 exactly when T is 1 or rmIn is nonzero.
- R6: Class 0x3 with function 0xB (subtract with overflow check) gives rnOut = rnIn − rmIn modulo 2^32. tOut is 1 exactly when the true signed difference falls outside the signed 32-bit range.
- R7: Class 0x6 with function 0xB gives rnOut = −rmIn, and class 0x6 with function 0x7 gives rnOut = ~rmIn. Both keep T.
- R8: Class 0x6 with function 0x8 gives rnOut = rmIn[31:16], then rmIn[7:0], then rmIn[15:8], from most to least significant, and keeps T.
- R9: Any other class or function value sets illegal to 1, with rnOut = rnIn and tOut = T. Bits 11:4 of the instruction word have no effect on any result.
- R10: In cycles after a cycle with inValid at 0, rnOut, tOut and illegal keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction and operands are present this cycle |
| opcode | input | 16 | Instruction word |
| rmIn | input | 32 | Source operand |
| rnIn | input | 32 | Current destination operand |
| tIn | input | 1 | Current T flag |
| outValid | output | 1 | Result registers were loaded at the last edge |
| rnOut | output | 32 | New destination value |
| tOut | output | 1 | New T flag |
| illegal | output | 1 | Last accepted instruction was not recognised |

## Verification
Every result is due exactly one rising edge after the edge that captured its instruction. The bench therefore drives inputs on the falling edge, queues the expected item at that moment, and compares on the next falling edge at which outValid is high. Because items leave the queue in order, any extra, missing or late result shows up as a mismatch or as a leftover count. On falling edges where outValid is low, the bench confirms that the outputs still show the last result.

// File: rtl/tflag_alu_pkg.sv
package tflag_alu_pkg;

  localparam int CLS_W = 4;
  localparam int FN_W  = 4;

  localparam logic [CLS_W-1:0] CLS_ARITH = 4'h3;
  localparam logic [CLS_W-1:0] CLS_UNARY = 4'h6;

  localparam logic [FN_W-1:0] FN_SUB  = 4'h8;
  localparam logic [FN_W-1:0] FN_SUBC = 4'hA;
  localparam logic [FN_W-1:0] FN_SUBV = 4'hB;
  localparam logic [FN_W-1:0] FN_NEGC = 4'hA;
  localparam logic [FN_W-1:0] FN_NEG  = 4'hB;
  localparam logic [FN_W-1:0] FN_NOT  = 4'h7;
  localparam logic [FN_W-1:0] FN_SWAP = 4'h8;

  typedef enum logic [1:0] {
    RES_DIFF = 2'd0,
    RES_INV  = 2'd1,
    RES_SWAP = 2'd2,
    RES_PASS = 2'd3
  } resSel_e;

  typedef enum logic [1:0] {
    T_KEEP   = 2'd0,
    T_BORROW = 2'd1,
    T_OVF    = 2'd2
  } tSel_e;

  typedef struct packed {
    logic    zeroA;
    logic    useT;
    resSel_e resSel;
    tSel_e   tSel;
    logic    illegal;
  } ctrlStrobe_t;

endpackage

// File: rtl/tflag_alu_ctrl.sv
module tflag_alu_ctrl
  import tflag_alu_pkg::*;
#(
  parameter int OPC_W = 16
) (
  input  logic [OPC_W-1:0] opcode,
  output ctrlStrobe_t      strobe
);

  logic [CLS_W-1:0] cls;
  logic [FN_W-1:0]  fn;

  assign cls = opcode[OPC_W-1 -: CLS_W];
  assign fn  = opcode[FN_W-1:0];

  always_comb begin
    strobe = '{zeroA: 1'b0, useT: 1'b0, resSel: RES_PASS, tSel: T_KEEP, illegal: 1'b1};
    unique case (cls)
      CLS_ARITH: begin
        unique case (fn)
          FN_SUB:  strobe = '{zeroA: 1'b0, useT: 1'b0, resSel: RES_DIFF, tSel: T_KEEP,   illegal: 1'b0};
          FN_SUBC: strobe = '{zeroA: 1'b0, useT: 1'b1, resSel: RES_DIFF, tSel: T_BORROW, illegal: 1'b0};
          FN_SUBV: strobe = '{zeroA: 1'b0, useT: 1'b0, resSel: RES_DIFF, tSel: T_OVF,    illegal: 1'b0};
          default: ;
        endcase
      end
      CLS_UNARY: begin
        unique case (fn)
          FN_NEGC: strobe = '{zeroA: 1'b1, useT: 1'b1, resSel: RES_DIFF, tSel: T_BORROW, illegal: 1'b0};
          FN_NEG:  strobe = '{zeroA: 1'b1, useT: 1'b0, resSel: RES_DIFF, tSel: T_KEEP,   illegal: 1'b0};
          FN_NOT:  strobe = '{zeroA: 1'b0, useT: 1'b0, resSel: RES_INV,  tSel: T_KEEP,   illegal: 1'b0};
          FN_SWAP: strobe = '{zeroA: 1'b0, useT: 1'b0, resSel: RES_SWAP, tSel: T_KEEP,   illegal: 1'b0};
          default: ;
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/tflag_alu_dp.sv
module tflag_alu_dp
  import tflag_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] rmIn,
  input  logic [DATA_W-1:0] rnIn,
  input  logic              tIn,
  output logic              outValid,
  output logic [DATA_W-1:0] rnOut,
  output logic              tOut,
  output logic              illegal
);

  localparam int BYTE_W = 8;
  localparam int HALF_W = 2 * BYTE_W;

  logic [DATA_W-1:0] opA;
  logic [DATA_W:0]   wideDiff;
  logic [DATA_W-1:0] diff;
  logic              borrowOut;
  logic              overflow;
  logic [DATA_W-1:0] swapped;
  logic [DATA_W-1:0] nextRes;
  logic              nextT;

  assign opA = strobe.zeroA ? '0 : rnIn;

  // One 33-bit subtract; the incoming T acts as a second borrow for the chained forms.
  assign wideDiff  = {1'b0, opA} - {1'b0, rmIn} - (DATA_W+1)'(strobe.useT & tIn);
  assign diff      = wideDiff[DATA_W-1:0];
  assign borrowOut = wideDiff[DATA_W];
  assign overflow  = ((rnIn[DATA_W-1] ^ rmIn[DATA_W-1]) & (diff[DATA_W-1] ^ rnIn[DATA_W-1]));

  generate
    if (DATA_W > HALF_W) begin : g_wideSwap
      assign swapped = {rmIn[DATA_W-1:HALF_W], rmIn[BYTE_W-1:0], rmIn[HALF_W-1:BYTE_W]};
    end else begin : g_narrowSwap
      assign swapped = {rmIn[BYTE_W-1:0], rmIn[HALF_W-1:BYTE_W]};
    end
  endgenerate

  always_comb begin
    unique case (strobe.resSel)
      RES_DIFF: nextRes = diff;
      RES_INV:  nextRes = ~rmIn;
      RES_SWAP: nextRes = swapped;
      default:  nextRes = rnIn;
    endcase
  end

  always_comb begin
    unique case (strobe.tSel)
      T_BORROW: nextT = borrowOut;
      T_OVF:    nextT = overflow;
      default:  nextT = tIn;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      rnOut    <= '0;
      tOut     <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        rnOut   <= nextRes;
        tOut    <= nextT;
        illegal <= strobe.illegal;
      end
    end
  end

endmodule

// File: rtl/tflag_alu.sv
module tflag_alu
  import tflag_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OPC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] rmIn,
  input  logic [DATA_W-1:0] rnIn,
  input  logic              tIn,
  output logic              outValid,
  output logic [DATA_W-1:0] rnOut,
  output logic              tOut,
  output logic              illegal
);

  ctrlStrobe_t strobe;

  tflag_alu_ctrl #(.OPC_W(OPC_W)) u_ctrl (
    .opcode (opcode),
    .strobe (strobe)
  );

  tflag_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .strobe   (strobe),
    .rmIn     (rmIn),
    .rnIn     (rnIn),
    .tIn      (tIn),
    .outValid (outValid),
    .rnOut    (rnOut),
    .tOut     (tOut),
    .illegal  (illegal)
  );

endmodule

// File: rtl/tflag_alu_chk.sv
module tflag_alu_chk #(
  parameter int DATA_W = 32,
  parameter int OPC_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic [OPC_W-1:0]  opcode,
  input logic [DATA_W-1:0] rmIn,
  input logic [DATA_W-1:0] rnIn,
  input logic              tIn,
  input logic              outValid,
  input logic [DATA_W-1:0] rnOut,
  input logic              tOut,
  input logic              illegal
);

  logic [3:0] cls;
  logic [3:0] fn;
  logic       knownOp;
  logic       isSub;
  logic       isNegc;
  logic       isSwap;

  assign cls     = opcode[OPC_W-1 -: 4];
  assign fn      = opcode[3:0];
  assign isSub   = (cls == 4'h3) && (fn == 4'h8);
  assign isNegc  = (cls == 4'h6) && (fn == 4'hA);
  assign isSwap  = (cls == 4'h6) && (fn == 4'h8);
  assign knownOp = ((cls == 4'h3) && ((fn == 4'h8) || (fn == 4'hA) || (fn == 4'hB))) ||
                   ((cls == 4'h6) && ((fn == 4'h7) || (fn == 4'h8) || (fn == 4'hA) || (fn == 4'hB)));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ($stable(rnOut) && $stable(tOut) && $stable(illegal)));

  assert_plain_sub_keeps_t_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && isSub) |=> (tOut == $past(tIn) && !illegal));

  assert_negc_borrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && isNegc && (tIn || (rmIn != '0))) |=> tOut);

  assert_swap_high_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && isSwap) |=> (rnOut[DATA_W-1:16] == $past(rmIn[DATA_W-1:16])));

  assert_illegal_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !knownOp) |=> (illegal && rnOut == $past(rnIn) && tOut == $past(tIn)));

  assert_legal_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && knownOp) |=> !illegal);

endmodule

bind tflag_alu tflag_alu_chk #(.DATA_W(DATA_W), .OPC_W(OPC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .opcode   (opcode),
  .rmIn     (rmIn),
  .rnIn     (rnIn),
  .tIn      (tIn),
  .outValid (outValid),
  .rnOut    (rnOut),
  .tOut     (tOut),
  .illegal  (illegal)
);

// File: tb/sim_tflag_alu.sv
`timescale 1ns/1ps
module sim_tflag_alu;

  typedef struct {
    logic [31:0] rn;
    logic        t;
    logic        ill;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] opcode = '0;
  logic [31:0] rmIn = '0;
  logic [31:0] rnIn = '0;
  logic        tIn = 1'b0;
  logic        outValid;
  logic [31:0] rnOut;
  logic        tOut;
  logic        illegal;

  int checks = 0;
  int fails = 0;
  int pushed = 0;
  int popped = 0;
  bit done = 1'b0;
  bit haveLast = 1'b0;
  logic [31:0] lastRn;
  logic        lastT;
  logic        lastIll;
  expItem_t    expQ[$];

  always #4 clk = ~clk;

  tflag_alu u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opcode(opcode),
    .rmIn(rmIn), .rnIn(rnIn), .tIn(tIn),
    .outValid(outValid), .rnOut(rnOut), .tOut(tOut), .illegal(illegal)
  );

  // Reference computed from the requirement text with wide signed integers.
  function automatic expItem_t refModel(input logic [15:0] op, input logic [31:0] rn,
                                        input logic [31:0] rm, input logic t);
    expItem_t e;
    longint a = longint'(rn);
    longint b = longint'(rm);
    longint d;
    logic [3:0] c = op[15:12];
    logic [3:0] f = op[3:0];
    e.rn = rn; e.t = t; e.ill = 1'b0; e.tag = "";
    if (c == 4'h3 && f == 4'h8) begin
      d = a - b; e.rn = d[31:0]; e.tag = "R3";
    end else if (c == 4'h3 && f == 4'hA) begin
      d = a - longint'(t) - b; e.rn = d[31:0]; e.t = (d < 0); e.tag = "R4";
    end else if (c == 4'h6 && f == 4'hA) begin
      d = 0 - longint'(t) - b; e.rn = d[31:0]; e.t = (d < 0); e.tag = "R5";
    end else if (c == 4'h3 && f == 4'hB) begin
      d = longint'($signed(rn)) - longint'($signed(rm));
      e.rn = d[31:0];
      e.t = (d > 64'sd2147483647) || (d < -64'sd2147483648);
      e.tag = "R6";
    end else if (c == 4'h6 && f == 4'hB) begin
      d = 0 - b; e.rn = d[31:0]; e.tag = "R7";
    end else if (c == 4'h6 && f == 4'h7) begin
      e.rn = rm ^ 32'hFFFF_FFFF; e.tag = "R7";
    end else if (c == 4'h6 && f == 4'h8) begin
      e.rn = {rm[31:16], rm[7:0], rm[15:8]}; e.tag = "R8";
    end else begin
      e.ill = 1'b1; e.tag = "R9";
    end
    return e;
  endfunction

  task automatic send(input logic [15:0] op, input logic [31:0] rn,
                      input logic [31:0] rm, input logic t);
    @(negedge clk);
    opcode = op; rnIn = rn; rmIn = rm; tIn = t; inValid = 1'b1;
    expQ.push_back(refModel(op, rn, rm, t));
    pushed++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      opcode = 16'hFFFF; rnIn = 32'hDEAD_BEEF; rmIn = 32'h1234_5678; tIn = ~tIn;
    end
  endtask

  // Monitor: results due one edge after capture, sampled on the falling edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (outValid) begin
        expItem_t e;
        if (expQ.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2: unexpected result rn=%h (expected none)", rnOut);
        end else begin
          e = expQ.pop_front();
          popped++;
          checks++;
          if (rnOut !== e.rn || tOut !== e.t || illegal !== e.ill) begin
            fails++;
            $display("FAIL %s: rn=%h t=%b ill=%b expected rn=%h t=%b ill=%b",
                     e.tag, rnOut, tOut, illegal, e.rn, e.t, e.ill);
          end
        end
        lastRn = rnOut; lastT = tOut; lastIll = illegal; haveLast = 1'b1;
      end else if (haveLast) begin
        checks++;
        if (rnOut !== lastRn || tOut !== lastT || illegal !== lastIll) begin
          fails++;
          $display("FAIL R10: rn=%h t=%b ill=%b expected rn=%h t=%b ill=%b",
                   rnOut, tOut, illegal, lastRn, lastT, lastIll);
        end
      end
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete (expected completion)");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state during reset
    checks++;
    if (outValid !== 1'b0 || illegal !== 1'b0 || rnOut !== 32'h0 || tOut !== 1'b0) begin
      fails++;
      $display("FAIL R1: v=%b ill=%b rn=%h t=%b expected all 0", outValid, illegal, rnOut, tOut);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: after release, before any instruction
    checks++;
    if (outValid !== 1'b0 || illegal !== 1'b0 || rnOut !== 32'h0 || tOut !== 1'b0) begin
      fails++;
      $display("FAIL R1: v=%b ill=%b rn=%h t=%b expected all 0", outValid, illegal, rnOut, tOut);
    end

    // R3 plain subtract, T kept both ways
    send(16'h3128, 32'd10, 32'd3, 1'b1);
    send(16'h3008, 32'd0, 32'd1, 1'b0);
    // R4 subtract with borrow: edges of the chained borrow
    send(16'h345A, 32'd0, 32'd0, 1'b1);
    send(16'h345A, 32'd5, 32'd4, 1'b1);
    send(16'h345A, 32'd5, 32'd5, 1'b1);
    send(16'h300A, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    send(16'h300A, 32'h8000_0000, 32'h0000_0001, 1'b0);
    idle(2);
    // R5 negate with borrow
    send(16'h6ABA, 32'h5555_5555, 32'd0, 1'b0);
    send(16'h6ABA, 32'h5555_5555, 32'd0, 1'b1);
    send(16'h600A, 32'd7, 32'd1, 1'b0);
    send(16'h600A, 32'd7, 32'hFFFF_FFFF, 1'b1);
    // R6 subtract with overflow detect
    send(16'h312B, 32'h8000_0000, 32'd1, 1'b0);
    send(16'h312B, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    send(16'h312B, 32'd5, 32'd3, 1'b1);
    send(16'h312B, 32'hFFFF_FFFE, 32'h7FFF_FFFF, 1'b1);
    idle(3);
    // R7 negate and invert
    send(16'h634B, 32'h0, 32'd1, 1'b1);
    send(16'h634B, 32'h0, 32'h8000_0000, 1'b0);
    send(16'h6347, 32'h1, 32'hA5A5_0F0F, 1'b1);
    // R8 byte swap of low half
    send(16'h6FF8, 32'h0, 32'h1234_5678, 1'b0);
    send(16'h6008, 32'h0, 32'hAABB_CCDD, 1'b1);
    idle(1);
    // R9 unrecognised encodings pass rn and T through
    send(16'h0000, 32'hCAFE_F00D, 32'h1, 1'b1);
    send(16'h3009, 32'h0BAD_0BAD, 32'h2, 1'b0);
    send(16'h6FF9, 32'h1111_2222, 32'h3, 1'b1);
    send(16'hF00A, 32'h0000_0042, 32'h4, 1'b0);
    // R9 register-number bits have no effect
    send(16'h3FFA, 32'd5, 32'd5, 1'b1);
    idle(4);

    // R2: one result per accepted instruction
    checks++;
    if (pushed != popped || expQ.size() != 0) begin
      fails++;
      $display("FAIL R2: results=%0d expected=%0d", popped, pushed);
    end
    done = 1'b1;
    finishRun();
  end

endmodule